// File: doc/BRIEF.md
# Peripheral Activity Detect Monitor

This block watches host bus traffic for signs of activity on the system's legacy peripherals. It snoops every I/O and memory cycle on the host bus and compares the address against a fixed set of windows: the disk channels, the floppy controller, two serial ports, the parallel port, the video adapter and the keyboard controller. It also samples three level inputs that report bus-master activity, primary interrupt activity and audio access. Each kind of event sets its own sticky status bit. Software clears a status bit by writing a one to it.

An enable register selects which status bits count as activity. When an enabled status bit is set, a sticky summary flag is set. The summary flag raises a system-management interrupt request when the global enable is on. It also fires a single-cycle reload strobe toward a first timer. A second reload strobe goes to another timer whenever one of the peripheral status bits (disk through keyboard) goes from clear to set and its own reload-enable bit is on. Power-management firmware uses these strobes to hold off idle timers while the machine is in use. The timers and the interrupt delivery logic live outside this block.

Top module: `pam_monitor`

## Requirements
- R1: The status register (select 0) holds 11 bits. Bit 0 is bus master, bit 1 is primary interrupt, bit 2 is primary disk (I/O 1F0h–1F7h, 3F6h), bit 3 is secondary disk (I/O 170h–177h, 376h), bit 4 is floppy (I/O 3F0h–3F5h, 3F7h), bit 5 is serial A (I/O 3E8h–3EFh, 3F8h–3FFh), bit 6 is serial B (I/O 2E8h–2EFh, 2F8h–2FFh), bit 7 is parallel (I/O 278h–27Fh, 378h–37Fh), bit 8 is video and bit 9 is keyboard controller (I/O 60h). A snooped cycle with `snp_valid` high whose address falls in a window sets the matching bit at the next clock edge. I/O cycles compare only the low 16 address bits.
- R2: The video bit is set by an I/O cycle to 3B0h–3DFh or by a memory cycle (`snp_is_io` low) to A0000h–BFFFFh. A memory cycle to any other address sets no bit, even when its address lies inside an I/O window.
- R3: The bus-master, interrupt and audio inputs are sampled on every clock. While an input is high, it sets status bit 0, 1 or 10 respectively.
- R4: All registers reset to 0. Writing a 1 to a status bit clears it, and writing a 0 leaves it unchanged. Bits 31 to 11 of every register read as 0.
- R5: If a hardware set and a software clear hit the same status bit in the same cycle, the bit ends up set.
- R6: Select 1 is an 11-bit read/write enable register. The summary flag (select 3, bit 0) is set one clock after any status bit is set while its enable bit is set. The flag is sticky, and writing a 1 to select 3 bit 0 clears it.
- R7: `smi_req` is high exactly while the summary flag is set and the global enable (select 3, bit 1, read/write) is set.
- R8: When the summary flag and the timer-0 reload enable (select 2, bit 0) are both set, `t0_reload` gives one single-cycle pulse, one clock after the condition becomes true. It pulses again only after the condition has gone false and then true again.
- R9: Select 2 bits 9 to 2 are timer-1 reload enables for status bits 9 to 2. `t1_reload` pulses for one cycle in the same cycle that any of those status bits goes from 0 to 1 while its reload enable is set.
- R10: `reg_rdata` shows the register picked by `reg_sel` combinationally. Select 2 bit 1 reads 0. Register writes take effect at the clock edge where `reg_wr` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| snp_valid | input | 1 | Snooped bus cycle is valid this clock |
| snp_is_io | input | 1 | 1 = I/O cycle, 0 = memory cycle |
| snp_addr | input | 20 | Snooped cycle address |
| bm_active | input | 1 | Bus-master activity level |
| irq_active | input | 1 | Primary interrupt activity level |
| audio_hit | input | 1 | Audio access level |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 status, 1 enable, 2 reload enables, 3 global |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for the selected register |
| smi_req | output | 1 | System-management interrupt request |
| t0_reload | output | 1 | Timer-0 reload strobe |
| t1_reload | output | 1 | Timer-1 reload strobe |

## Verification
The assertions assume that the reset is released synchronously. They also assume that register writes, snooped cycles and the activity levels are sampled only at the rising edge and are stable around it. The bench drives every input just after the falling edge to keep within this.

The assertions do not depend on which peripheral windows are hit, since the windows never overlap. The random stimulus therefore mixes window edge addresses, addresses just outside the windows, arbitrary addresses and memory cycles freely. It also writes arbitrary data to any register at any time, including clears in the same cycle as new events.

// File: rtl/pam_pkg.sv
package pam_pkg;
    localparam int NSRC   = 11;
    localparam int ADDR_W = 20;
    localparam int NWIN   = 15;

    // status bit positions (software decodes these)
    localparam int B_BM   = 0;
    localparam int B_IRQ  = 1;
    localparam int B_PDSK = 2;
    localparam int B_SDSK = 3;
    localparam int B_FLOP = 4;
    localparam int B_SERA = 5;
    localparam int B_SERB = 6;
    localparam int B_PAR  = 7;
    localparam int B_VID  = 8;
    localparam int B_KBC  = 9;
    localparam int B_AUD  = 10;

    // reload-enable range for timer 1
    localparam int T1_LO = B_PDSK;
    localparam int T1_HI = B_KBC;
    localparam int T1_W  = T1_HI - T1_LO + 1;

    typedef logic [NSRC-1:0] src_vec_t;

    typedef enum logic [1:0] {
        SEL_STATUS = 2'd0,
        SEL_ENABLE = 2'd1,
        SEL_RELOAD = 2'd2,
        SEL_GLOBAL = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [3:0]        idx;
        logic              is_mem;
        logic [ADDR_W-1:0] lo;
        logic [ADDR_W-1:0] hi;
    } win_t;

    localparam win_t WIN_TBL [NWIN] = '{
        '{4'd2,  1'b0, 20'h001F0, 20'h001F7},
        '{4'd2,  1'b0, 20'h003F6, 20'h003F6},
        '{4'd3,  1'b0, 20'h00170, 20'h00177},
        '{4'd3,  1'b0, 20'h00376, 20'h00376},
        '{4'd4,  1'b0, 20'h003F0, 20'h003F5},
        '{4'd4,  1'b0, 20'h003F7, 20'h003F7},
        '{4'd5,  1'b0, 20'h003E8, 20'h003EF},
        '{4'd5,  1'b0, 20'h003F8, 20'h003FF},
        '{4'd6,  1'b0, 20'h002E8, 20'h002EF},
        '{4'd6,  1'b0, 20'h002F8, 20'h002FF},
        '{4'd7,  1'b0, 20'h00278, 20'h0027F},
        '{4'd7,  1'b0, 20'h00378, 20'h0037F},
        '{4'd8,  1'b0, 20'h003B0, 20'h003DF},
        '{4'd8,  1'b1, 20'hA0000, 20'hBFFFF},
        '{4'd9,  1'b0, 20'h00060, 20'h00060}
    };
endpackage

// File: rtl/pam_decode.sv
module pam_decode
    import pam_pkg::*;
#(
    parameter int IO_W = 16
) (
    input  logic              valid,
    input  logic              is_io,
    input  logic [ADDR_W-1:0] addr,
    output src_vec_t          hit
);
    localparam int PAD_W = ADDR_W - IO_W;

    logic [ADDR_W-1:0] cmp_addr;
    logic [NWIN-1:0]   win_hit;

    always_comb begin
        cmp_addr = is_io ? {{PAD_W{1'b0}}, addr[IO_W-1:0]} : addr;
    end

    for (genvar w = 0; w < NWIN; w++) begin : g_win
        assign win_hit[w] = valid
                         && (is_io != WIN_TBL[w].is_mem)
                         && (cmp_addr >= WIN_TBL[w].lo)
                         && (cmp_addr <= WIN_TBL[w].hi);
    end

    always_comb begin
        hit = '0;
        for (int w = 0; w < NWIN; w++) begin
            if (win_hit[w]) hit[WIN_TBL[w].idx] = 1'b1;
        end
    end

    // windows are disjoint: at most one window matches a cycle (R1)
    always_comb begin
        if (valid === 1'b1) begin
            p_disjoint_r1: assert ($onehot0(win_hit));
        end
    end
endmodule

// File: rtl/pam_status.sv
module pam_status
    import pam_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  src_vec_t set_vec,
    input  src_vec_t clr_vec,
    input  src_vec_t en_vec,
    input  logic     sum_clr,
    output src_vec_t status_q,
    output logic     sum_q,
    output src_vec_t newly
);
    typedef struct packed {
        src_vec_t st;
        logic     sum;
    } st_t;

    st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        // set has priority over clear so no event is dropped
        s_d.st  = (s_q.st & ~clr_vec) | set_vec;
        s_d.sum = (s_q.sum & ~sum_clr) | (|(s_q.st & en_vec));
        newly   = s_d.st & ~s_q.st;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign status_q = s_q.st;
    assign sum_q    = s_q.sum;

    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((~status_q & $past(status_q) & ~$past(clr_vec)) == '0));

    p_set_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((~status_q & $past(set_vec)) == '0));

    p_sum_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sum_q) |-> $past((status_q & en_vec) != '0));
endmodule

// File: rtl/pam_reload.sv
module pam_reload
    import pam_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     sum,
    input  logic     t0_en,
    input  src_vec_t newly,
    input  src_vec_t t1_mask,
    output logic     t0_pulse,
    output logic     t1_pulse
);
    typedef struct packed {
        logic cond_prev;
        logic t0;
        logic t1;
    } rl_t;

    rl_t r_d, r_q;
    logic cond;

    always_comb begin
        cond          = sum & t0_en;
        r_d           = r_q;
        r_d.cond_prev = cond;
        r_d.t0        = cond & ~r_q.cond_prev;
        r_d.t1        = |(newly & t1_mask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign t0_pulse = r_q.t0;
    assign t1_pulse = r_q.t1;

    p_t0_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        t0_pulse |=> !t0_pulse);
endmodule

// File: rtl/pam_monitor.sv
module pam_monitor
    import pam_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IO_W   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              snp_valid,
    input  logic              snp_is_io,
    input  logic [ADDR_W-1:0] snp_addr,
    input  logic              bm_active,
    input  logic              irq_active,
    input  logic              audio_hit,
    input  logic              reg_wr,
    input  logic [1:0]        reg_sel,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              smi_req,
    output logic              t0_reload,
    output logic              t1_reload
);
    typedef struct packed {
        src_vec_t        en;
        logic            t0_en;
        logic [T1_W-1:0] t1_en;
        logic            glb_en;
    } cfg_t;

    cfg_t     c_d, c_q;
    src_vec_t win_hit, set_vec, clr_vec, status_q, newly, t1_mask;
    logic     sum_q, sum_clr;
    reg_sel_e sel;
    logic     unused_wdata;

    assign sel          = reg_sel_e'(reg_sel);
    assign unused_wdata = ^reg_wdata[DATA_W-1:NSRC];

    pam_decode #(.IO_W(IO_W)) u_dec (
        .valid (snp_valid),
        .is_io (snp_is_io),
        .addr  (snp_addr),
        .hit   (win_hit)
    );

    always_comb begin
        set_vec        = win_hit;
        set_vec[B_BM]  = win_hit[B_BM]  | bm_active;
        set_vec[B_IRQ] = win_hit[B_IRQ] | irq_active;
        set_vec[B_AUD] = win_hit[B_AUD] | audio_hit;
        clr_vec        = (reg_wr && sel == SEL_STATUS) ? reg_wdata[NSRC-1:0] : '0;
        sum_clr        = reg_wr && sel == SEL_GLOBAL && reg_wdata[0];
        t1_mask        = '0;
        t1_mask[T1_HI:T1_LO] = c_q.t1_en;
    end

    always_comb begin
        c_d = c_q;
        if (reg_wr) begin
            case (sel)
                SEL_ENABLE: c_d.en = reg_wdata[NSRC-1:0];
                SEL_RELOAD: begin
                    c_d.t0_en = reg_wdata[0];
                    c_d.t1_en = reg_wdata[T1_HI:T1_LO];
                end
                SEL_GLOBAL: c_d.glb_en = reg_wdata[1];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    pam_status u_st (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_vec  (set_vec),
        .clr_vec  (clr_vec),
        .en_vec   (c_q.en),
        .sum_clr  (sum_clr),
        .status_q (status_q),
        .sum_q    (sum_q),
        .newly    (newly)
    );

    pam_reload u_rl (
        .clk      (clk),
        .rst_n    (rst_n),
        .sum      (sum_q),
        .t0_en    (c_q.t0_en),
        .newly    (newly),
        .t1_mask  (t1_mask),
        .t0_pulse (t0_reload),
        .t1_pulse (t1_reload)
    );

    always_comb begin
        reg_rdata = '0;
        case (sel)
            SEL_STATUS: reg_rdata[NSRC-1:0] = status_q;
            SEL_ENABLE: reg_rdata[NSRC-1:0] = c_q.en;
            SEL_RELOAD: begin
                reg_rdata[0]           = c_q.t0_en;
                reg_rdata[T1_HI:T1_LO] = c_q.t1_en;
            end
            default: begin
                reg_rdata[0] = sum_q;
                reg_rdata[1] = c_q.glb_en;
            end
        endcase
    end

    assign smi_req = sum_q & c_q.glb_en;

    p_t1_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        t1_reload |-> ((status_q & ~$past(status_q) & $past(t1_mask)) != '0));

    p_smi_needs_sum_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(smi_req) |-> (reg_sel != 2'd3 || reg_rdata[0]));
endmodule

// File: tb/tb_pam_monitor.sv
`timescale 1ns/1ps
module tb_pam_monitor;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        snp_valid = 0, snp_is_io = 0;
    logic [19:0] snp_addr = '0;
    logic        bm_active = 0, irq_active = 0, audio_hit = 0;
    logic        reg_wr = 0;
    logic [1:0]  reg_sel = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        smi_req, t0_reload, t1_reload;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // model state
    logic [10:0] m_st = '0, m_en = '0;
    logic [7:0]  m_t1m = '0;
    logic        m_t0e = 0, m_gen = 0, m_sum = 0, m_prev = 0, m_t0 = 0, m_t1 = 0;

    always #2.5 clk = ~clk;

    pam_monitor dut (
        .clk(clk), .rst_n(rst_n), .snp_valid(snp_valid), .snp_is_io(snp_is_io),
        .snp_addr(snp_addr), .bm_active(bm_active), .irq_active(irq_active),
        .audio_hit(audio_hit), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .smi_req(smi_req),
        .t0_reload(t0_reload), .t1_reload(t1_reload)
    );

    function automatic logic [10:0] dec_m(logic v, logic io, logic [19:0] a);
        logic [10:0] r = '0;
        logic [15:0] p = a[15:0];
        if (!v) return r;
        if (!io) begin
            if (a >= 20'hA0000 && a <= 20'hBFFFF) r[8] = 1;
            return r;
        end
        if ((p >= 16'h1F0 && p <= 16'h1F7) || p == 16'h3F6) r[2] = 1;
        if ((p >= 16'h170 && p <= 16'h177) || p == 16'h376) r[3] = 1;
        if ((p >= 16'h3F0 && p <= 16'h3F5) || p == 16'h3F7) r[4] = 1;
        if (p[15:3] == 13'h7F || p[15:3] == 13'h7D) r[5] = 1;
        if (p[15:3] == 13'h5F || p[15:3] == 13'h5D) r[6] = 1;
        if (p[15:3] == 13'h6F || p[15:3] == 13'h4F) r[7] = 1;
        if (p >= 16'h3B0 && p <= 16'h3DF) r[8] = 1;
        if (p == 16'h060) r[9] = 1;
        return r;
    endfunction

    function automatic logic [31:0] rd_m(logic [1:0] s);
        case (s)
            2'd0: return {21'd0, m_st};
            2'd1: return {21'd0, m_en};
            2'd2: return {22'd0, m_t1m, 1'b0, m_t0e};
            default: return {30'd0, m_gen, m_sum};
        endcase
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic idle();
        snp_valid = 0; snp_is_io = 0; snp_addr = '0;
        bm_active = 0; irq_active = 0; audio_hit = 0;
        reg_wr = 0; reg_wdata = '0;
    endtask

    // advance one clock, update model, compare every output
    task automatic step();
        logic [10:0] h, clr, stn, newb;
        logic n_sum, n_t0, n_t1, n_prev, cond;
        h = dec_m(snp_valid, snp_is_io, snp_addr);
        h[0] |= bm_active; h[1] |= irq_active; h[10] |= audio_hit;
        clr  = (reg_wr && reg_sel == 2'd0) ? reg_wdata[10:0] : 11'd0;
        stn  = (m_st & ~clr) | h;
        newb = stn & ~m_st;
        n_t1 = |(newb[9:2] & m_t1m);
        n_sum = (m_sum & ~(reg_wr && reg_sel == 2'd3 && reg_wdata[0])) | (|(m_st & m_en));
        cond = m_sum & m_t0e;
        n_t0 = cond & ~m_prev;
        n_prev = cond;
        @(posedge clk);
        @(negedge clk);
        if (reg_wr) begin
            if (reg_sel == 2'd1) m_en = reg_wdata[10:0];
            if (reg_sel == 2'd2) begin m_t0e = reg_wdata[0]; m_t1m = reg_wdata[9:2]; end
            if (reg_sel == 2'd3) m_gen = reg_wdata[1];
        end
        m_st = stn; m_sum = n_sum; m_t0 = n_t0; m_t1 = n_t1; m_prev = n_prev;
        check("R7 smi_req", {31'd0, smi_req}, {31'd0, m_sum & m_gen});
        check("R8 t0_reload", {31'd0, t0_reload}, {31'd0, m_t0});
        check("R9 t1_reload", {31'd0, t1_reload}, {31'd0, m_t1});
        check("R10 reg_rdata", reg_rdata, rd_m(reg_sel));
    endtask

    task automatic wr(logic [1:0] s, logic [31:0] d);
        reg_wr = 1; reg_sel = s; reg_wdata = d;
        step();
        idle();
    endtask

    task automatic io(logic isio, logic [19:0] a);
        snp_valid = 1; snp_is_io = isio; snp_addr = a;
        step();
        idle();
    endtask

    function automatic logic [19:0] pick_addr();
        logic [19:0] tbl [24] = '{20'h1EF, 20'h1F0, 20'h1F7, 20'h1F8, 20'h3F6, 20'h170,
            20'h177, 20'h376, 20'h3F0, 20'h3F5, 20'h3F7, 20'h3F8, 20'h3FF, 20'h3E8,
            20'h2F8, 20'h2EF, 20'h278, 20'h37F, 20'h3B0, 20'h3DF, 20'h060, 20'hA0000,
            20'hBFFFF, 20'hC0000};
        if ($urandom % 4 == 0) return 20'($urandom);
        return tbl[$urandom % 24];
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'd2024);
        idle();
        repeat (3) @(negedge clk);
        rst_n = 1;
        // reset state (R4)
        for (int s = 0; s < 4; s++) begin
            reg_sel = 2'(s);
            #0.1;
            check("R4 reset value", reg_rdata, 32'd0);
        end
        reg_sel = 0;
        step();
        // R1: floppy at 3F7h sets bit 4
        io(1, 20'h3F7);
        check("R1 floppy bit", reg_rdata, 32'h10);
        // R4: write zero keeps, write one clears
        wr(0, 32'h0);
        check("R4 write0 keeps", reg_rdata, 32'h10);
        wr(0, 32'hFFFF_FFEF);
        check("R4 other-bit clear keeps", reg_rdata, 32'h10);
        wr(0, 32'h10);
        check("R4 write1 clears", reg_rdata, 32'h0);
        // R2: memory cycle to I/O-like address sets nothing; video memory sets bit 8
        io(0, 20'h003F8);
        check("R2 mem outside video", reg_rdata, 32'h0);
        io(0, 20'hBFFFF);
        check("R2 video memory", reg_rdata, 32'h100);
        wr(0, 32'h100);
        // R3: levels
        bm_active = 1; irq_active = 1; audio_hit = 1; step(); idle();
        check("R3 level inputs", reg_rdata, 32'h403);
        wr(0, 32'h7FF);
        check("R4 full clear", reg_rdata, 32'h0);
        // R5: set and clear same bit same cycle
        snp_valid = 1; snp_is_io = 1; snp_addr = 20'h1F0;
        reg_wr = 1; reg_sel = 0; reg_wdata = 32'h4;
        step(); idle();
        check("R5 set wins", reg_rdata, 32'h4);
        // R6/R7/R8: enable bit 2, timer-0 reload and global
        wr(2, 32'h1);
        wr(3, 32'h2);
        reg_sel = 3;
        wr(1, 32'h4);
        reg_sel = 3; step();
        check("R6 summary set", reg_rdata, 32'h3);
        check("R7 smi asserted", {31'd0, smi_req}, 32'd1);
        step();
        check("R8 t0 pulse", {31'd0, t0_reload}, 32'd1);
        step();
        check("R8 t0 single", {31'd0, t0_reload}, 32'd0);
        // R9: keyboard reload enable bit 9
        wr(2, 32'h200);
        io(1, 20'h060);
        check("R9 t1 pulse on new kbc", {31'd0, t1_reload}, 32'd1);
        io(1, 20'h060);
        check("R9 no pulse when already set", {31'd0, t1_reload}, 32'd0);
        // random phase
        for (int i = 0; i < 4000; i++) begin
            snp_valid  = ($urandom % 3) != 0;
            snp_is_io  = ($urandom % 4) != 0;
            snp_addr   = pick_addr();
            bm_active  = ($urandom % 12) == 0;
            irq_active = ($urandom % 12) == 0;
            audio_hit  = ($urandom % 12) == 0;
            reg_wr     = ($urandom % 4) == 0;
            reg_sel    = 2'($urandom);
            reg_wdata  = $urandom;
            step();
        end
        idle();
        step();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule